// File: doc/BRIEF.md
# Write-once watchdog and stop controller

This block sits in the system-options area of a small microcontroller. It holds a configuration byte with three working bits: a watchdog enable, a watchdog period select and a stop-permission bit. The configuration byte takes exactly one write after each reset. It also contains the watchdog counter, which runs on the bus clock, and it raises a one-cycle reset request whose cause code tells the reset logic why the request was made.

Software keeps the watchdog quiet by writing a two-byte key to the service port: 0x55 first, then 0xAA. When the CPU executes a stop instruction while stop is not permitted, the block raises a reset request of its own kind instead of letting stop proceed. The CPU, the low-power sequencing and the reset pin are outside this block. The system is expected to answer a request by driving `rstN` low.

Top module: `sysopt_guard`

## Requirements
- R1: After reset the configuration reads 0x03. Bit 0 is the watchdog enable (1), bit 1 is the period select (1 = long), bit 2 is the stop permission (0 = stop forbidden), and bits 7:3 read 0.
- R2: The first configuration write after reset loads bits 2:0 from the write data. Bits 7:3 still read 0.
- R3: Once any configuration write has been accepted, every later write leaves the configuration unchanged until the next reset.
- R4: While the watchdog is enabled, a reset request with cause 01 appears in the cycle after 2^SHORT_LOG2 (period select 0) or 2^LONG_LOG2 (period select 1) enabled clock edges have passed since the counter was last cleared. The defaults are 13 and 18.
- R5: A service write of 0xAA clears the counter only when the service write just before it carried 0x55. Any other service value drops that pending state, and 0xAA alone has no effect. Idle cycles between the two writes do not break the sequence.
- R6: While the watchdog enable is 0, the counter stays at zero and no cause-01 request occurs.
- R7: A stop strobe while stop is forbidden gives a reset request with cause 10 in the next cycle. While stop is permitted, a stop strobe gives no request.
- R8: The reset request is high for one cycle per event. The cause reads 00 whenever no request is high. If a timeout and an illegal stop fall on the same edge, only the timeout (01) is reported.
- R9: After a timeout the counter restarts from zero, so an unserviced watchdog times out again after one more full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Current configuration value |
| svcWrEn | input | 1 | Service-port write strobe |
| svcWrData | input | 8 | Service-port write data |
| stopExec | input | 1 | Stop instruction executed |
| rstReq | output | 1 | One-cycle reset request |
| rstCause | output | 2 | Cause code: 01 timeout, 10 illegal stop, 00 idle |

## Verification
Every result is one register away from its stimulus. A configuration write shows on the read port after the next clock edge. A completed service key zeroes the counter on the edge that takes the 0xAA byte. A timeout or an illegal stop raises the request after the edge on which it is detected. The bench drives inputs on falling edges. A behavioural model updates on each rising edge from the same inputs. Outputs are compared against the model on every falling edge, so each check falls in the half cycle after the edge that is due to change the result. Directed checks taken right after each stimulus task confirm the one-cycle latency and the exact spacing between timeouts.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int DATA_W     = 8;
  localparam int CFG_BITS   = 3;
  localparam int BIT_COPEN  = 0;
  localparam int BIT_LONG   = 1;
  localparam int BIT_STOPEN = 2;
  localparam logic [CFG_BITS-1:0] CFG_RST = 3'b011;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WDT  = 2'b01,
    CAUSE_STOP = 2'b10
  } rstCause_e;

  typedef struct packed {
    logic wdtOn;
    logic longSel;
    logic cntClr;
    logic stopTrap;
  } ctrlStrobe_t;
endpackage

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
  import sysopt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              svcWrEn,
  input  logic [DATA_W-1:0] svcWrData,
  input  logic              stopExec,
  output logic [DATA_W-1:0] cfgRdData,
  output ctrlStrobe_t       strobe
);
  localparam int PAD_W = DATA_W - CFG_BITS;

  logic [CFG_BITS-1:0] cfgBits;
  logic                locked;
  logic                armed;
  logic                svcHit;
  logic                cfgTake;

  assign cfgTake = cfgWrEn && !locked;
  assign svcHit  = svcWrEn && (svcWrData == KEY_FIRE) && armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits <= CFG_RST;
      locked  <= 1'b0;
    end else if (cfgTake) begin
      cfgBits <= cfgWrData[CFG_BITS-1:0];
      locked  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (svcWrEn) begin
      armed <= (svcWrData == KEY_ARM);
    end
  end

  assign cfgRdData       = {{PAD_W{1'b0}}, cfgBits};
  assign strobe.wdtOn    = cfgBits[BIT_COPEN];
  assign strobe.longSel  = cfgBits[BIT_LONG];
  assign strobe.cntClr   = !cfgBits[BIT_COPEN] || svcHit;
  assign strobe.stopTrap = stopExec && !cfgBits[BIT_STOPEN];

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(cfgBits)); // R3
  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !locked) |=> (locked && cfgBits == $past(cfgWrData[CFG_BITS-1:0]))); // R2
  AST_ARM_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (svcWrEn && svcWrData != KEY_ARM) |=> !armed); // R5
endmodule

// File: rtl/sysopt_datapath.sv
module sysopt_datapath
  import sysopt_pkg::*;
#(
  parameter int SHORT_LOG2 = 13,
  parameter int LONG_LOG2  = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        rstReq,
  output logic [1:0]  rstCause
);
  localparam int CNT_W = LONG_LOG2;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);
  localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             atLast;
  logic             timeout;
  logic             reqQ;
  rstCause_e        causeQ;

  assign atLast  = strobe.longSel ? (cnt == LONG_LAST) : (cnt >= SHORT_LAST);
  assign timeout = !strobe.cntClr && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClr || atLast) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      reqQ <= timeout || strobe.stopTrap;
      if (timeout)              causeQ <= CAUSE_WDT;
      else if (strobe.stopTrap) causeQ <= CAUSE_STOP;
      else                      causeQ <= CAUSE_NONE;
    end
  end

  assign rstReq   = reqQ;
  assign rstCause = causeQ;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cnt == '0)); // R5
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wdtOn |=> !(rstReq && rstCause == CAUSE_WDT)); // R6
  AST_LONG_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wdtOn && !strobe.cntClr && strobe.longSel && cnt == LONG_LAST)
      |=> (rstReq && rstCause == CAUSE_WDT)); // R4
  AST_STOP_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopTrap && !timeout) |=> (rstReq && rstCause == CAUSE_STOP)); // R7
  AST_CAUSE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (rstCause == CAUSE_WDT || rstCause == CAUSE_STOP)); // R8
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rstReq |-> (rstCause == CAUSE_NONE)); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && rstCause == CAUSE_WDT) |-> (cnt == '0)); // R9
endmodule

// File: rtl/sysopt_guard.sv
module sysopt_guard
  import sysopt_pkg::*;
#(
  parameter int SHORT_LOG2 = 13,
  parameter int LONG_LOG2  = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  input  logic        svcWrEn,
  input  logic [7:0]  svcWrData,
  input  logic        stopExec,
  output logic        rstReq,
  output logic [1:0]  rstCause
);
  ctrlStrobe_t strobe;

  sysopt_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .svcWrEn   (svcWrEn),
    .svcWrData (svcWrData),
    .stopExec  (stopExec),
    .cfgRdData (cfgRdData),
    .strobe    (strobe)
  );

  sysopt_datapath #(
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rstReq   (rstReq),
    .rstCause (rstCause)
  );
endmodule

// File: tb/tb_sysopt_guard.sv
`timescale 1ns/1ps
module tb_sysopt_guard;
  localparam int SHORT_LOG2 = 5;
  localparam int LONG_LOG2  = 8;
  localparam int SHORT_P = 1 << SHORT_LOG2;
  localparam int LONG_P  = 1 << LONG_LOG2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       svcWrEn = 1'b0;
  logic [7:0] svcWrData = 8'h00;
  logic       stopExec = 1'b0;
  logic       rstReq;
  logic [1:0] rstCause;

  sysopt_guard #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .svcWrEn(svcWrEn), .svcWrData(svcWrData),
    .stopExec(stopExec), .rstReq(rstReq), .rstCause(rstCause)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wdtPulses = 0;
  string curReq = "R1";

  // behavioural reference
  logic [2:0] mCfg = 3'b011;
  bit         mLocked = 0;
  bit         mArmed = 0;
  int         mCount = 0;
  bit         mReq = 0;
  int         mCause = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 3'b011; mLocked = 0; mArmed = 0; mCount = 0; mReq = 0; mCause = 0;
    end else begin
      bit tmo;
      bit trap;
      bit svcOk;
      int per;
      tmo   = 0;
      trap  = stopExec && !mCfg[2];
      per   = mCfg[1] ? LONG_P : SHORT_P;
      svcOk = svcWrEn && svcWrData == 8'hAA && mArmed;
      if (!mCfg[0] || svcOk) mCount = 0;
      else if (mCount >= per - 1) begin mCount = 0; tmo = 1; end
      else mCount++;
      if (svcWrEn) mArmed = (svcWrData == 8'h55);
      mReq   = tmo || trap;
      mCause = tmo ? 1 : (trap ? 2 : 0);
      if (cfgWrEn && !mLocked) begin mCfg = cfgWrData[2:0]; mLocked = 1; end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (cfgRdData !== {5'b0, mCfg} || rstReq !== mReq || rstCause !== 2'(mCause)) begin
        errors++;
        $display("FAIL %s: cfg=%h req=%b cause=%0d expected cfg=%h req=%b cause=%0d",
                 curReq, cfgRdData, rstReq, rstCause, {5'b0, mCfg}, mReq, mCause);
      end
      if (rstReq && rstCause == 2'b01) wdtPulses++;
    end
  end

  task automatic expectEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic svcWrite(input logic [7:0] d);
    @(negedge clk); svcWrEn = 1'b1; svcWrData = d;
    @(negedge clk); svcWrEn = 1'b0;
  endtask

  task automatic stopPulse();
    @(negedge clk); stopExec = 1'b1;
    @(negedge clk); stopExec = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    expectEq("R1", int'(cfgRdData), 8'h03);

    curReq = "R4";
    base = wdtPulses;
    idle(LONG_P + 20);
    expectEq("R4", wdtPulses - base, 1);

    curReq = "R5";
    base = wdtPulses;
    for (int i = 0; i < 8; i++) begin
      idle(LONG_P - 60);
      svcWrite(8'h55);
      idle(3);
      svcWrite(8'hAA);
    end
    expectEq("R5", wdtPulses - base, 0);
    svcWrite(8'h55); svcWrite(8'h12); svcWrite(8'hAA);
    svcWrite(8'hAA);
    idle(LONG_P);

    curReq = "R7";
    svcWrite(8'h55); svcWrite(8'hAA);
    stopPulse();
    expectEq("R7", int'(rstReq), 1);
    expectEq("R7", int'(rstCause), 2);
    @(negedge clk);
    expectEq("R8", int'(rstReq), 0);

    curReq = "R8";
    @(negedge clk); stopExec = 1'b1;
    idle(2 * LONG_P + 40);
    stopExec = 1'b0;
    idle(4);

    curReq = "R2";
    doReset();
    cfgWrite(8'hFE);
    expectEq("R2", int'(cfgRdData), 8'h06);
    curReq = "R3";
    cfgWrite(8'h01);
    expectEq("R3", int'(cfgRdData), 8'h06);
    curReq = "R6";
    base = wdtPulses;
    idle(3 * LONG_P);
    expectEq("R6", wdtPulses - base, 0);
    curReq = "R7";
    stopPulse();
    expectEq("R7", int'(rstReq), 0);

    curReq = "R4";
    doReset();
    cfgWrite(8'h01);
    expectEq("R2", int'(cfgRdData), 8'h01);
    idle(2 * SHORT_P);
    curReq = "R9";
    @(negedge clk);
    while (!(rstReq && rstCause == 2'b01)) @(negedge clk);
    begin
      int gap = 0;
      do begin @(negedge clk); gap++; end while (!(rstReq && rstCause == 2'b01));
      expectEq("R9", gap, SHORT_P);
    end

    curReq = "R1";
    idle(7);
    doReset();
    expectEq("R1", int'(cfgRdData), 8'h03);
    expectEq("R1", int'(rstReq), 0);
    idle(20);
    finishRun();
  end
endmodule